// File: doc/BRIEF.md
# Mode-Dependent Indicator Blinker and Alarm Burst Generator

This block turns one base clock into two slow outputs for a battery-charger controller. An indicator output toggles at a rate chosen by the operating mode. A 2-bit select picks charge, trickle charge or alarm, and each mode has its own half-period. The half-periods are parameters, counted in base-clock cycles.

The second output is an alarm burst for a buzzer. A trigger starts a train of square-wave periods at 50% duty. The burst runs a fixed number of periods and then stops, and the output stays low until the next trigger. A trigger that arrives while a burst is running is dropped, so bursts never queue. A synchronous reset clears both counters, drives the indicator low and cancels any burst that is running.

Top module: `indicator_alarm_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both outputs are low after that edge. Any burst in progress is cancelled, and the indicator count restarts from zero.
- R2: `mode_sel` is decoded as follows: 2'b00 selects charge, 2'b01 selects trickle, 2'b10 selects alarm, and the unused code 2'b11 behaves exactly like charge.
- R3: In charge mode with `CHG_HALF` = H, the value of `led_out` after n clock edges since reset is floor(n/H) mod 2.
- R4: In trickle mode, the rule of R3 applies with H = `TRK_HALF`.
- R5: In alarm mode, the rule of R3 applies with H = `ALM_HALF`.
- R6: If `alarm_trig` is high at an edge while no burst is running, `burst_out` is high right after that edge.
- R7: Number the start edge j = 1. After edge j, for j up to 2·`BURST_HALF`·`BURST_PERIODS`, `burst_out` is high exactly when ((j-1) mod 2·`BURST_HALF`) < `BURST_HALF`. After that, `burst_out` is low.
- R8: A trigger that is high while a burst is running has no effect, and this includes the burst's final cycle. The burst ends on its original schedule.
- R9: `burst_out` is low whenever no burst is running. A trigger given after a burst has ended starts a new, complete burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Operating mode select (see R2) |
| alarm_trig | input | 1 | Starts a burst when no burst is running |
| led_out | output | 1 | Indicator square wave |
| burst_out | output | 1 | Alarm burst square wave |

## Verification
The indicator is tested with all four select codes in turn, each run over several full periods. Because every mode has a different half-period, a wrong decode or an off-by-one count shows up as a wrong level. Running code 2'b11 separately shows whether it really falls back to charge. The burst is tested four ways: a single clean trigger, retriggers in mid-burst and on the final cycle, a fresh trigger after the burst ends, and a reset in mid-burst. Together these tell a correct stop apart from an extended burst, a queued burst and a burst that survives reset.

// File: rtl/indicator_alarm_gen.sv
module indicator_alarm_gen #(
  parameter int CHG_HALF      = 6,
  parameter int TRK_HALF      = 3,
  parameter int ALM_HALF      = 10,
  parameter int BURST_HALF    = 8,
  parameter int BURST_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       alarm_trig,
  output logic       led_out,
  output logic       burst_out
);

  localparam int LED_MAX   = (CHG_HALF > TRK_HALF) ?
                             ((CHG_HALF > ALM_HALF) ? CHG_HALF : ALM_HALF) :
                             ((TRK_HALF > ALM_HALF) ? TRK_HALF : ALM_HALF);
  localparam int LW        = $clog2(LED_MAX + 1);
  localparam int BURST_LEN = 2 * BURST_HALF * BURST_PERIODS;
  localparam int BW        = $clog2(BURST_LEN + 1);
  localparam logic [31:0] PER_LEN  = 32'(2 * BURST_HALF);
  localparam logic [31:0] HIGH_LEN = 32'(BURST_HALF);

  logic [LW-1:0] led_cnt;
  logic [LW-1:0] led_lim;
  logic          burst_act;
  logic [BW-1:0] burst_cnt;

  always_comb begin
    case (mode_sel)
      2'b01:   led_lim = LW'(TRK_HALF - 1);
      2'b10:   led_lim = LW'(ALM_HALF - 1);
      default: led_lim = LW'(CHG_HALF - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_cnt <= '0;
      led_out <= 1'b0;
    end else if (led_cnt >= led_lim) begin
      led_cnt <= '0;
      led_out <= ~led_out;
    end else begin
      led_cnt <= led_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_act <= 1'b0;
      burst_cnt <= '0;
    end else if (!burst_act) begin
      burst_act <= alarm_trig;
      burst_cnt <= '0;
    end else if (burst_cnt == BW'(BURST_LEN - 1)) begin
      burst_act <= 1'b0;
      burst_cnt <= '0;
    end else begin
      burst_cnt <= burst_cnt + 1'b1;
    end
  end

  assign burst_out = burst_act && ((32'(burst_cnt) % PER_LEN) < HIGH_LEN);

endmodule

// File: rtl/indicator_alarm_gen_chk.sv
module indicator_alarm_gen_chk #(
  parameter int LW        = 4,
  parameter int BW        = 7,
  parameter int BURST_LEN = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          alarm_trig,
  input logic          led_out,
  input logic          burst_out,
  input logic          burst_act,
  input logic [BW-1:0] burst_cnt,
  input logic [LW-1:0] led_cnt
);

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (!led_out && !burst_out && !burst_act)); // R1

  AST_LED_WRAP: assert property (@(posedge clk) disable iff (rst)
    (led_out != $past(led_out)) |-> (led_cnt == '0)); // R3

  AST_BURST_START: assert property (@(posedge clk) disable iff (rst)
    (!burst_act && alarm_trig) |=> burst_out); // R6

  AST_BURST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (burst_act && burst_cnt != BW'(BURST_LEN - 1)) |=>
      (burst_act && (burst_cnt - $past(burst_cnt)) == BW'(1))); // R8

  AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
    (burst_act && burst_cnt == BW'(BURST_LEN - 1)) |=> (!burst_act && !burst_out)); // R7

endmodule

bind indicator_alarm_gen indicator_alarm_gen_chk #(
  .LW(LW), .BW(BW), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk(clk), .rst(rst), .alarm_trig(alarm_trig), .led_out(led_out),
  .burst_out(burst_out), .burst_act(burst_act), .burst_cnt(burst_cnt),
  .led_cnt(led_cnt)
);

// File: tb/indicator_alarm_gen_tb.sv
`timescale 1ns/1ps
module indicator_alarm_gen_tb;

  localparam int CHG = 6;
  localparam int TRK = 3;
  localparam int ALM = 10;
  localparam int BH  = 8;
  localparam int BP  = 4;
  localparam int BLEN = 2 * BH * BP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic alarm_trig = 1'b0;
  logic led_out, burst_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  indicator_alarm_gen #(
    .CHG_HALF(CHG), .TRK_HALF(TRK), .ALM_HALF(ALM),
    .BURST_HALF(BH), .BURST_PERIODS(BP)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .alarm_trig(alarm_trig),
    .led_out(led_out), .burst_out(burst_out)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 led after reset", led_out, 1'b0);
    chk("R1 burst after reset", burst_out, 1'b0);
  endtask

  function automatic logic burst_exp(input int j);
    if (j < 1 || j > BLEN) return 1'b0;
    return ((j - 1) % (2 * BH)) < BH;
  endfunction

  initial begin
    @(negedge clk);
    do_reset();

    // R2 R3 R4 R5: sweep every select code
    for (int sel = 0; sel < 4; sel++) begin
      int h;
      string tag;
      mode_sel = 2'(sel);
      case (sel)
        1: begin h = TRK; tag = "R4 trickle led"; end
        2: begin h = ALM; tag = "R5 alarm led"; end
        3: begin h = CHG; tag = "R2 code 11 falls back to charge"; end
        default: begin h = CHG; tag = "R3 charge led"; end
      endcase
      do_reset();
      for (int n = 1; n <= 4 * h + 3; n++) begin
        step();
        chk(tag, led_out, logic'((n / h) % 2));
      end
    end

    // R6 R7 R8: single burst with retriggers mid-burst and on final cycle
    mode_sel = 2'b00;
    do_reset();
    alarm_trig = 1'b1;
    for (int j = 1; j <= BLEN + 16; j++) begin
      step();
      alarm_trig = (j == 19 || j == BLEN);
      if (j == 1) chk("R6 burst starts high", burst_out, 1'b1);
      else if (j <= BLEN) chk("R7 burst shape", burst_out, burst_exp(j));
      else chk("R8 retrigger ignored, burst stopped", burst_out, 1'b0);
    end

    // R9: fresh trigger after end starts a complete burst
    alarm_trig = 1'b1;
    for (int j = 1; j <= BLEN + 4; j++) begin
      step();
      alarm_trig = 1'b0;
      chk("R9 new burst after idle", burst_out, burst_exp(j));
    end

    // R1: reset cancels burst
    alarm_trig = 1'b1;
    step();
    alarm_trig = 1'b0;
    for (int j = 0; j < 4; j++) step();
    chk("R6 burst running before reset", burst_out, burst_exp(5));
    do_reset();
    for (int j = 0; j < BLEN; j++) begin
      step();
      chk("R1 burst cancelled by reset", burst_out, 1'b0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule